// File: doc/BRIEF.md
# Byte ALU with Bit-Test and Read-Modify-Write Operations

This block is the arithmetic and logic data path of an 8-bit accumulator processor. Each cycle it takes an operation code, the accumulator, a memory operand, an immediate mask, a bit-select control and the incoming N, V, Z and C flags. On the next rising clock edge it registers three outputs: a result byte bound for the accumulator, a write-back byte bound for memory, and the updated flags.

The operations are binary add and subtract with carry, compare, AND, OR and XOR, four shifts and rotates of the memory operand, two non-destructive bit tests (one against the accumulator and one against an immediate mask), test-and-set and test-and-reset of memory bits, and setting or clearing a single memory bit. A decimal-mode input is accepted, but arithmetic stays binary whatever its value. Operand fetch, addressing and sequencing are handled elsewhere.

Top module: `byte_alu`

## Requirements
- R1: While rst_n is low, and after the first edge with it low, result, wback and flags_out are all zero. flags_in and flags_out are packed as {N,V,Z,C}, with N in bit 3.
- R2: Op 0 (add) gives S = acc + mem + C. result and the new C are S[7:0] and S[8]. V is set when acc and mem have the same sign and result has the other sign. N is result[7]. Z is (result == 0).
- R3: Op 1 (subtract) behaves exactly as op 0 with mem replaced by its bitwise inverse. For ops 0 and 1 the dec input has no effect on any output.
- R4: Op 2 (compare) sets C when acc >= mem as unsigned numbers, and takes N and Z from (acc - mem) mod 256. V is unchanged and result equals acc.
- R5: Ops 3, 4 and 5 (AND, OR, XOR) put acc op mem on result and take N and Z from it.
- R6: Ops 6 to 9 (shift left, shift right, rotate left, rotate right) act on mem and put the value on both result and wback. The shifts bring in 0 and the rotates bring in the old C. The bit that leaves becomes the new C, and N and Z come from the new value.
- R7: Op 10 (bit test) sets N = mem[7], V = mem[6] and Z = ((acc & mem) == 0), leaves C unchanged, and sets result = acc.
- R8: Op 11 (mask test) follows the rules of op 10, but Z = ((mask & mem) == 0).
- R9: Op 12 (test-and-set) sets wback = acc | mem. Op 13 (test-and-reset) sets wback = mem & ~acc. For both, N, V and Z come from bit 7, bit 6 and zero-ness of wback, C is unchanged, and result = acc.
- R10: Op 14 (single-bit modify) copies mem to wback with bit bit_ctl[2:0] forced to bit_ctl[3]. All flags are unchanged and result = acc.
- R11: Any flag that an operation does not define keeps its flags_in value. Op 15 gives result = acc, wback = mem and flags_out = flags_in. For every op other than 6 to 9 and 12 to 14, wback equals mem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| mem | input | 8 | Memory operand |
| mask | input | 8 | Immediate mask for mask test |
| bit_ctl | input | 4 | {set, bit index} for single-bit modify |
| flags_in | input | 4 | Incoming {N,V,Z,C} |
| dec | input | 1 | Decimal-mode flag (ignored) |
| result | output | 8 | Registered accumulator result |
| wback | output | 8 | Registered memory write-back byte |
| flags_out | output | 4 | Registered {N,V,Z,C} |

## Verification
The assertions check, on every cycle, the add carry and sum, the compare carry, the sign and overflow copies of the bit test, the test-and-set write-back, the one-bit difference of a single-bit modify, and that logic ops preserve V and C. Only the bench's scenarios can show the full flag sets. These include overflow at the signed boundaries, subtraction through the inverted operand, the choice of input the mask test uses, the rotate carry paths, and the absence of any effect from the decimal input.

// File: rtl/byte_alu.sv
module byte_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op,
  input  logic [7:0] acc,
  input  logic [7:0] mem,
  input  logic [7:0] mask,
  input  logic [3:0] bit_ctl,
  input  logic [3:0] flags_in,
  input  logic       dec,
  output logic [7:0] result,
  output logic [7:0] wback,
  output logic [3:0] flags_out
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_AND = 4'd3,
                         OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_SHL = 4'd6,  OP_SHR = 4'd7,
                         OP_ROL = 4'd8,  OP_ROR = 4'd9,  OP_BIT = 4'd10, OP_TST = 4'd11,
                         OP_TSB = 4'd12, OP_TRB = 4'd13, OP_BMD = 4'd14;

  logic       fn, fv, fz, fc;
  assign {fn, fv, fz, fc} = flags_in;

  logic [7:0] addend;
  logic [8:0] sum;
  logic [8:0] diff;
  assign addend = (op == OP_SUB) ? ~mem : mem;
  assign sum    = {1'b0, acc} + {1'b0, addend} + {8'd0, fc};
  assign diff   = {1'b0, acc} - {1'b0, mem};

  logic       unused_dec;
  assign unused_dec = dec;

  logic [7:0] r_d, w_d, tmask;
  logic       n_d, v_d, z_d, c_d;

  always_comb begin
    r_d = acc;
    w_d = mem;
    n_d = fn; v_d = fv; z_d = fz; c_d = fc;
    tmask = 8'd0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        r_d = sum[7:0];
        c_d = sum[8];
        v_d = (acc[7] == addend[7]) && (sum[7] != acc[7]);
        n_d = sum[7];
        z_d = (sum[7:0] == 8'd0);
      end
      OP_CMP: begin
        c_d = ~diff[8];
        n_d = diff[7];
        z_d = (diff[7:0] == 8'd0);
      end
      OP_AND, OP_OR, OP_XOR: begin
        r_d = (op == OP_AND) ? (acc & mem) : (op == OP_OR) ? (acc | mem) : (acc ^ mem);
        n_d = r_d[7];
        z_d = (r_d == 8'd0);
      end
      OP_SHL, OP_ROL: begin
        r_d = {mem[6:0], (op == OP_ROL) ? fc : 1'b0};
        w_d = r_d;
        c_d = mem[7];
        n_d = r_d[7];
        z_d = (r_d == 8'd0);
      end
      OP_SHR, OP_ROR: begin
        r_d = {(op == OP_ROR) ? fc : 1'b0, mem[7:1]};
        w_d = r_d;
        c_d = mem[0];
        n_d = r_d[7];
        z_d = (r_d == 8'd0);
      end
      OP_BIT, OP_TST: begin
        tmask = (op == OP_TST) ? mask : acc;
        n_d = mem[7];
        v_d = mem[6];
        z_d = ((tmask & mem) == 8'd0);
      end
      OP_TSB, OP_TRB: begin
        w_d = (op == OP_TSB) ? (acc | mem) : ((acc | mem) ^ acc);
        n_d = w_d[7];
        v_d = w_d[6];
        z_d = (w_d == 8'd0);
      end
      OP_BMD: begin
        w_d = mem;
        w_d[bit_ctl[2:0]] = bit_ctl[3];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= 8'd0;
      wback     <= 8'd0;
      flags_out <= 4'd0;
    end else begin
      result    <= r_d;
      wback     <= w_d;
      flags_out <= {n_d, v_d, z_d, c_d};
    end
  end

  p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_ADD) |->
      ({flags_out[0], result} == {1'b0, $past(acc)} + {1'b0, $past(mem)} + {8'd0, $past(flags_in[0])}));

  p_cmp_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_CMP) |-> (flags_out[0] == ($past(acc) >= $past(mem))));

  p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op) == OP_AND || $past(op) == OP_OR || $past(op) == OP_XOR)) |->
      (flags_out[2] == $past(flags_in[2]) && flags_out[0] == $past(flags_in[0])));

  p_bit_nv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_BIT) |->
      (flags_out[3] == $past(mem[7]) && flags_out[2] == $past(mem[6]) && result == $past(acc)));

  p_tsb_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_TSB) |-> (wback == ($past(acc) | $past(mem))));

  p_bmd_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == OP_BMD) |->
      ($countones(wback ^ $past(mem)) <= 1 && flags_out == $past(flags_in)));
endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] acc = 8'd0, mem = 8'd0, mask = 8'd0;
  logic [3:0] bit_ctl = 4'd0, flags_in = 4'd0;
  logic       dec = 1'b0;
  logic [7:0] result, wback;
  logic [3:0] flags_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  byte_alu u_byte_alu (.clk(clk), .rst_n(rst_n), .op(op), .acc(acc), .mem(mem), .mask(mask),
    .bit_ctl(bit_ctl), .flags_in(flags_in), .dec(dec), .result(result), .wback(wback),
    .flags_out(flags_out));

  function automatic string tag(input int o);
    case (o)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3, 4, 5: return "R5"; 6, 7, 8, 9: return "R6";
      10: return "R7"; 11: return "R8"; 12, 13: return "R9";
      14: return "R10"; default: return "R11";
    endcase
  endfunction

  // returns {result, wback, N, V, Z, C}
  function automatic logic [19:0] model(input int o, input int a, input int m, input int k,
                                        input int bc, input logic [3:0] fi);
    int r = a, w = m, n = fi[3], v = fi[2], z = fi[1], c = fi[0], s, mm, t;
    case (o)
      0, 1: begin
        mm = (o == 1) ? (255 - m) : m;
        s = a + mm + c;
        r = s % 256; c = s / 256;
        v = (((a ^ r) & (mm ^ r) & 128) != 0);
        n = r / 128; z = (r == 0);
      end
      2: begin
        c = (a >= m);
        t = (a - m + 256) % 256;
        n = t / 128; z = (t == 0);
      end
      3, 4, 5: begin
        r = (o == 3) ? (a & m) : (o == 4) ? (a | m) : (a ^ m);
        n = r / 128; z = (r == 0);
      end
      6, 8: begin
        r = (m * 2) % 256 + ((o == 8) ? c : 0);
        c = m / 128; w = r; n = r / 128; z = (r == 0);
      end
      7, 9: begin
        r = m / 2 + ((o == 9) ? c * 128 : 0);
        c = m % 2; w = r; n = r / 128; z = (r == 0);
      end
      10, 11: begin
        n = m / 128; v = (m / 64) % 2;
        z = (((o == 11 ? k : a) & m) == 0);
      end
      12, 13: begin
        w = (o == 12) ? (a | m) : (m & (255 - a));
        n = w / 128; v = (w / 64) % 2; z = (w == 0);
      end
      14: begin
        t = 1 << (bc % 8);
        w = (bc >= 8) ? (m | t) : (m & (255 - t));
      end
      default: ;
    endcase
    return {r[7:0], w[7:0], n[0], v[0], z[0], c[0]};
  endfunction

  task automatic compare(input string rq, input logic [19:0] exp);
    checks++;
    if ({result, wback, flags_out} !== exp) begin
      fails++;
      $display("FAIL %s: got res=%02h wb=%02h f=%04b, expected res=%02h wb=%02h f=%04b",
               rq, result, wback, flags_out, exp[19:12], exp[11:4], exp[3:0]);
    end
  endtask

  // drive at negedge, check at next negedge after one posedge
  task automatic apply(input int o, input int a, input int m, input int k, input int bc,
                       input logic [3:0] fi, input logic d);
    logic [19:0] exp;
    op = o[3:0]; acc = a[7:0]; mem = m[7:0]; mask = k[7:0]; bit_ctl = bc[3:0];
    flags_in = fi; dec = d;
    exp = model(o, a, m, k, bc, fi);
    @(negedge clk);
    compare(tag(o), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", 20'd0);
    rst_n = 1'b1;
    apply(0, 8'h7F, 8'h01, 0, 0, 4'b0000, 0);
    apply(0, 8'hFF, 8'h01, 0, 0, 4'b0000, 0);
    apply(0, 8'h80, 8'h80, 0, 0, 4'b0001, 0);
    apply(0, 8'h12, 8'h34, 0, 0, 4'b0001, 1);
    apply(1, 8'h50, 8'hF0, 0, 0, 4'b0001, 0);
    apply(1, 8'h80, 8'h01, 0, 0, 4'b0001, 1);
    apply(1, 8'h00, 8'h00, 0, 0, 4'b0000, 1);
    apply(2, 8'h40, 8'h40, 0, 0, 4'b0100, 0);
    apply(2, 8'h10, 8'h20, 0, 0, 4'b0101, 0);
    apply(3, 8'hF0, 8'h0F, 0, 0, 4'b0111, 0);
    apply(5, 8'hAA, 8'h55, 0, 0, 4'b0000, 0);
    apply(6, 0, 8'h80, 0, 0, 4'b0000, 0);
    apply(8, 0, 8'h40, 0, 0, 4'b0001, 0);
    apply(7, 0, 8'h01, 0, 0, 4'b0000, 0);
    apply(9, 0, 8'h02, 0, 0, 4'b0001, 0);
    apply(10, 8'h3F, 8'hC0, 0, 0, 4'b0001, 0);
    apply(11, 8'hFF, 8'hC0, 8'h3F, 0, 4'b0000, 0);
    apply(11, 8'h00, 8'h41, 8'h01, 0, 4'b1011, 0);
    apply(12, 8'h40, 8'h01, 0, 0, 4'b0001, 0);
    apply(13, 8'hFF, 8'h5A, 0, 0, 4'b1101, 0);
    apply(14, 0, 8'h00, 0, 4'b1111, 4'b1010, 0);
    apply(14, 0, 8'hFF, 0, 4'b0011, 4'b0101, 0);
    apply(15, 8'h33, 8'h44, 0, 0, 4'b1001, 0);
    for (int i = 0; i < 600; i++)
      apply(i % 16, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 15), 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: got timeout, expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule